// File: doc/BRIEF.md
# Three-Segment Pipelined Multiply-Add

This block evaluates `A*B + C` on a continuous stream of unsigned operand sets. It takes one new set per clock and returns one result per clock once the pipe is full. The work is cut into three register-bounded segments. The first segment latches A and B. The second segment forms their product and, on the same edge, latches C. The third segment adds the latched C to the latched product.

Because C is captured one segment after A and B, the caller presents each item's C on the clock after that item's A and B. The product and C then reach the adder together, and no delay register is spent on C. A valid flag travels with each item, so the stream may contain gaps. The result port keeps its last value while no new result is flagged.

Top module: `madd_pipe`

## Requirements
- R1: When `in_vld` is high in a cycle, `op_a` and `op_b` of that cycle are taken as one item. When `in_vld` is low, `op_a` and `op_b` are ignored and no result is produced for that cycle.
- R2: `rst` is synchronous and active high. It clears every valid flag, so `out_vld` is low in the cycle after any reset cycle. Items in flight at reset never come out. No data register loads in a reset cycle, so `result` keeps its previous value.
- R3: The C operand of an item is the `op_c` value presented in the cycle right after that item's A and B. The `op_c` value presented together with A and B has no effect on that item.
- R4: If an item is presented in cycle n, `out_vld` is high in cycle n+3. In any cycle where no item was presented three cycles earlier, `out_vld` is low.
- R5: A flagged `result` equals A*B + C as a 33-bit unsigned value. Operands are 16-bit unsigned, and the full-scale case 65535*65535 + 65535 = 4294901760 is exact.
- R6: Back-to-back items presented in consecutive cycles come out in consecutive cycles with no gap. Seven items presented in cycles 0 to 6 are flagged in cycles 3 to 9.
- R7: While `out_vld` is low, `result` holds the last flagged value. Items separated by idle cycles come out in order, with the same spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| in_vld | input | 1 | Qualifies `op_a` and `op_b` in the current cycle |
| op_a | input | 16 | Multiplicand A |
| op_b | input | 16 | Multiplier B |
| op_c | input | 16 | Addend C, presented one cycle after its A and B |
| out_vld | output | 1 | Marks `result` as a new result in this cycle |
| result | output | 33 | A*B + C of the item leaving segment three |

## Verification
The hardest condition to reach is a reset that lands while items sit in the middle segments. This is the only way a product can be ready for the adder while its valid flag is being withdrawn. The bench sends two items and raises reset on the cycle the first item reaches the adder. It then watches four cycles for a stray flag or a changed result. The skewed C timing is covered by placing a decoy value on `op_c` in each item's A/B cycle. In a dense stream, each item's C also lines up with the next item's A and B.

// File: rtl/madd_pkg.sv
package madd_pkg;

    localparam int OP_W       = 16;
    localparam int PROD_W     = 2 * OP_W;
    localparam int SUM_W      = PROD_W + 1;
    localparam int PIPE_DEPTH = 3;

    typedef logic [OP_W-1:0]   op_t;
    typedef logic [PROD_W-1:0] prod_t;
    typedef logic [SUM_W-1:0]  sum_t;

    // contents of the segment-one register bank
    typedef struct packed {
        logic vld;
        op_t  a;
        op_t  b;
    } seg1_t;

    // contents of the segment-two register bank
    typedef struct packed {
        logic  vld;
        prod_t prod;
        op_t   c;
    } seg2_t;

    // contents of the result register
    typedef struct packed {
        logic vld;
        sum_t sum;
    } seg3_t;

    function automatic prod_t mul_u(input op_t x, input op_t y);
        return prod_t'(x) * prod_t'(y);
    endfunction

    function automatic sum_t add_u(input prod_t p, input op_t c);
        return sum_t'(p) + sum_t'(c);
    endfunction

endpackage

// File: rtl/madd_seg_load.sv
module madd_seg_load
    import madd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  vld_i,
    input  op_t   a_i,
    input  op_t   b_i,
    output seg1_t q_o
);
    seg1_t q;

    always_ff @(posedge clk) begin
        if (rst) q.vld <= 1'b0;
        else     q.vld <= vld_i;
    end

    // operand bank: no reset, loads only for a qualified item
    always_ff @(posedge clk) begin
        if (vld_i && !rst) begin
            q.a <= a_i;
            q.b <= b_i;
        end
    end

    assign q_o = q;
endmodule

// File: rtl/madd_seg_mul.sv
module madd_seg_mul
    import madd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  seg1_t d_i,
    input  op_t   c_i,
    output seg2_t q_o
);
    seg2_t q;
    prod_t prod_c;

    assign prod_c = mul_u(d_i.a, d_i.b);

    always_ff @(posedge clk) begin
        if (rst) q.vld <= 1'b0;
        else     q.vld <= d_i.vld;
    end

    // C is sampled here, one edge after its A and B
    always_ff @(posedge clk) begin
        if (d_i.vld && !rst) begin
            q.prod <= prod_c;
            q.c    <= c_i;
        end
    end

    assign q_o = q;
endmodule

// File: rtl/madd_seg_add.sv
module madd_seg_add
    import madd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  seg2_t d_i,
    output seg3_t q_o
);
    seg3_t q;
    sum_t  sum_c;

    assign sum_c = add_u(d_i.prod, d_i.c);

    always_ff @(posedge clk) begin
        if (rst) q.vld <= 1'b0;
        else     q.vld <= d_i.vld;
    end

    // result holds between flagged items
    always_ff @(posedge clk) begin
        if (d_i.vld && !rst) q.sum <= sum_c;
    end

    assign q_o = q;
endmodule

// File: rtl/madd_pipe.sv
module madd_pipe
    import madd_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_vld,
    input  logic [OP_W-1:0]        op_a,
    input  logic [OP_W-1:0]        op_b,
    input  logic [OP_W-1:0]        op_c,
    output logic                   out_vld,
    output logic [SUM_W-1:0]       result
);
    seg1_t s1;
    seg2_t s2;
    seg3_t s3;

    madd_seg_load u_load (
        .clk   (clk),
        .rst   (rst),
        .vld_i (in_vld),
        .a_i   (op_a),
        .b_i   (op_b),
        .q_o   (s1)
    );

    madd_seg_mul u_mul (
        .clk (clk),
        .rst (rst),
        .d_i (s1),
        .c_i (op_c),
        .q_o (s2)
    );

    madd_seg_add u_add (
        .clk (clk),
        .rst (rst),
        .d_i (s2),
        .q_o (s3)
    );

    assign out_vld = s3.vld;
    assign result  = s3.sum;
endmodule

// File: rtl/madd_pipe_chk.sv
module madd_pipe_chk
    import madd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_vld,
    input logic [OP_W-1:0]  op_a,
    input logic [OP_W-1:0]  op_b,
    input logic [OP_W-1:0]  op_c,
    input logic             out_vld,
    input logic [SUM_W-1:0] result
);
    localparam int CW = $clog2(PIPE_DEPTH + 1);

    logic [CW-1:0] since_rst;
    logic          seen_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
            seen_out  <= 1'b0;
        end else begin
            if (since_rst != CW'(PIPE_DEPTH)) since_rst <= since_rst + 1'b1;
            seen_out <= seen_out | out_vld;
        end
    end

    // R2: reset withdraws every flag
    a_r2_reset_clears: assert property (@(posedge clk)
        rst |=> !out_vld);

    // R4: flag emerges three cycles after the item
    a_r4_latency: assert property (@(posedge clk) disable iff (rst)
        (since_rst == CW'(PIPE_DEPTH)) |-> (out_vld == $past(in_vld, 3)));

    // R5 and R3: value uses A,B three back and C two back
    a_r5_value: assert property (@(posedge clk) disable iff (rst)
        (since_rst == CW'(PIPE_DEPTH) && out_vld) |->
        (result == (sum_t'($past(op_a, 3)) * sum_t'($past(op_b, 3))
                    + sum_t'($past(op_c, 2)))));

    // R7: result frozen while unflagged
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (seen_out && !out_vld) |-> $stable(result));

    // R5: top bit never needed for 16-bit operands
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> !result[SUM_W-1]);
endmodule

bind madd_pipe madd_pipe_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .op_a    (op_a),
    .op_b    (op_b),
    .op_c    (op_c),
    .out_vld (out_vld),
    .result  (result)
);

// File: tb/madd_pipe_tb_top.sv
`timescale 1ns/1ps
module madd_pipe_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_vld;
    logic [15:0] op_a, op_b, op_c;
    logic        out_vld;
    logic [32:0] result;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [15:0] sa [16];
    logic [15:0] sb [16];
    logic [15:0] sc [16];
    bit          sv [16];
    logic [32:0] exp_res;
    bit          have_exp = 1'b0;
    int          first_cyc, last_cyc, n_out;

    always #2.5 clk = ~clk;

    madd_pipe dut_i (
        .clk(clk), .rst(rst), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
        .op_c(op_c), .out_vld(out_vld), .result(result)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drives items from the arrays; C is driven one cycle after its A/B
    task automatic run_stream(input int n, input string tag);
        first_cyc = -1; last_cyc = -1; n_out = 0;
        for (int cyc = 0; cyc <= n + 3; cyc++) begin
            @(negedge clk);
            if (cyc >= 3) begin
                int k = cyc - 3;
                bit ev = (k < n) ? sv[k] : 1'b0;
                chk(out_vld == ev, {tag, " R4 flag"}, 64'(out_vld), 64'(ev));
                if (ev) begin
                    exp_res = 33'(sa[k]) * 33'(sb[k]) + 33'(sc[k]);
                    have_exp = 1'b1;
                    chk(result == exp_res, {tag, " R5 value"}, 64'(result), 64'(exp_res));
                end else if (have_exp) begin
                    chk(result == exp_res, {tag, " R7 hold"}, 64'(result), 64'(exp_res));
                end
            end
            if (out_vld) begin
                if (first_cyc < 0) first_cyc = cyc;
                last_cyc = cyc;
                n_out++;
            end
            in_vld = (cyc < n) ? sv[cyc] : 1'b0;
            op_a   = (cyc < n) ? sa[cyc] : 16'hA5A5;
            op_b   = (cyc < n) ? sb[cyc] : 16'h5A5A;
            // R3 decoy on op_c in the item's own A/B cycle when nothing is due
            if (cyc >= 1 && cyc <= n) op_c = sc[cyc-1];
            else                      op_c = 16'hBEEF;
        end
    endtask

    task automatic t_reset_state();
        rst = 1'b1; in_vld = 1'b1; op_a = 16'd9; op_b = 16'd9; op_c = 16'd9;
        repeat (3) @(negedge clk);
        chk(out_vld == 1'b0, "R2 reset state", 64'(out_vld), 64'd0);
        rst = 1'b0; in_vld = 1'b0;
    endtask

    task automatic t_single();
        sa[0] = 16'd3; sb[0] = 16'd5; sc[0] = 16'd7; sv[0] = 1'b1;
        run_stream(1, "single R1 R3");
        chk(n_out == 1, "R4 single count", 64'(n_out), 64'd1);
    endtask

    task automatic t_stream7();
        for (int i = 0; i < 7; i++) begin
            sa[i] = 16'(100 + 37 * i); sb[i] = 16'(2000 - 91 * i);
            sc[i] = 16'(11 * i + 1);   sv[i] = 1'b1;
        end
        run_stream(7, "stream R6");
        chk(first_cyc == 3, "R6 first result cycle", 64'(first_cyc), 64'd3);
        chk(last_cyc == 9, "R6 last result cycle", 64'(last_cyc), 64'd9);
        chk(n_out == 7, "R6 result count", 64'(n_out), 64'd7);
    endtask

    task automatic t_maxval();
        sa[0] = 16'hFFFF; sb[0] = 16'hFFFF; sc[0] = 16'hFFFF; sv[0] = 1'b1;
        sa[1] = 16'd0;    sb[1] = 16'hFFFF; sc[1] = 16'd0;    sv[1] = 1'b1;
        sa[2] = 16'hFFFF; sb[2] = 16'd1;    sc[2] = 16'hFFFF; sv[2] = 1'b1;
        run_stream(3, "maxval R5");
        chk(have_exp && exp_res == 33'd131070, "R5 last edge value", 64'(exp_res), 64'd131070);
    endtask

    task automatic t_gaps();
        bit pat [8] = '{1, 0, 1, 0, 0, 1, 1, 0};
        for (int i = 0; i < 8; i++) begin
            sa[i] = 16'(700 + 13 * i); sb[i] = 16'(50 + 3 * i);
            sc[i] = 16'(9000 + i);     sv[i] = pat[i];
        end
        run_stream(8, "gaps R1 R7");
        chk(n_out == 4, "R1 ignored cycles", 64'(n_out), 64'd4);
    endtask

    task automatic t_reset_flush();
        @(negedge clk);
        in_vld = 1'b1; op_a = 16'd40; op_b = 16'd41; op_c = 16'hBEEF;
        @(negedge clk);
        in_vld = 1'b1; op_a = 16'd42; op_b = 16'd43; op_c = 16'd44;
        @(negedge clk);
        rst = 1'b1; in_vld = 1'b1; op_a = 16'd1; op_b = 16'd1; op_c = 16'd45;
        @(negedge clk);
        rst = 1'b0; in_vld = 1'b0; op_c = 16'd0;
        chk(out_vld == 1'b0, "R2 flag after reset", 64'(out_vld), 64'd0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(out_vld == 1'b0, "R2 flushed item", 64'(out_vld), 64'd0);
            chk(result == exp_res, "R2 data untouched", 64'(result), 64'(exp_res));
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_single();
        t_stream7();
        t_maxval();
        t_gaps();
        t_reset_flush();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule